// File: doc/BRIEF.md
# Mezzanine Slot Power Sequencer

This block is a board-controller state machine that powers a mezzanine card slot. It starts only when two inputs are active: a software enable and an active-low card-present signal. It then turns on three slot rails in a fixed order: the 12 V rail, then the adjustable rail, then the 3.3 V rail. Before each next step it waits for the power-good input of the rail it has just enabled. When all three rails are good, it drives the carrier-to-mezzanine power-good output high.

The adjustable-rail voltage code comes from three DIP switches. If all three switches are OFF, the code comes from three software GPIO inputs instead. The block also drives a pre-driver supply select that matches the chosen code. The code is captured when a sequence starts and is held while the slot is powered.

Each waiting step has a parameterised timeout. When it expires, all slot rails turn off and the block latches a fault. If the start condition is lost, the rails turn off in reverse order. All inputs are already synchronous to `clk_i`.

Top module: `fmc_pwr_seq`

## Requirements
- R1: A sequence starts only while `sw_en_i` is 1 and `card_prsnt_ni` is 0. With either input inactive, every enable output stays 0.
- R2: One clock after the start condition is sampled in idle, `en_12v_o` goes high. The other enables stay low until `pg_12v_i` is seen.
- R3: `en_adj_o` goes high one clock after `pg_12v_i` is sampled high in the 12 V step. It is never high without `en_12v_o`.
- R4: `en_3v3_o` goes high one clock after `pg_adj_i` is sampled high in the adjustable step. It is never high without `en_adj_o`.
- R5: `pg_c2m_o` goes high one clock after `pg_3v3_i` is sampled high in the 3.3 V step. It is only ever high while all three enables are high.
- R6: `dip_i` holds the switches with bit 2 = C, bit 1 = B and bit 0 = A, where ON reads as 0. When `dip_i` is not 3'b111, the voltage code `vcode_o` equals `dip_i`. The codes are: 000 = 3.3 V, 001 = 2.5 V, 010 = 1.8 V, 011 = 1.5 V, 100 = 1.25 V, 101 = 1.2 V, 110 = 0.8 V.
- R7: When `dip_i` is 3'b111, `vcode_o` takes the value of `gpio_code_i`.
- R8: `vccpd_sel_o` is 1 exactly when the latched code is 000 (the 3.3 V pre-driver) and 0 for every other code.
- R9: A step may wait at most TIMEOUT_CYC clock cycles for its power-good input. If that many cycles pass without it, the next clock turns off all enables and raises `fault_o`. The fault holds while the start condition stays true and clears to idle once it is lost.
- R10: If the start condition is lost, the rails turn off in reverse order, one step per clock: first `pg_c2m_o`, then `en_3v3_o`, then `en_adj_o`, then `en_12v_o`. The sequence begins at whichever step is currently reached.
- R11: The code is captured on the start clock. `vcode_o` and `vccpd_sel_o` do not change while `en_adj_o` is high.
- R12: After reset all enables, `pg_c2m_o` and `fault_o` are 0, `vcode_o` is 3'b110 and `vccpd_sel_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_en_i | input | 1 | Software slot power request |
| card_prsnt_ni | input | 1 | Card present, active low |
| dip_i | input | 3 | Voltage switches {C,B,A}, ON = 0 |
| gpio_code_i | input | 3 | Software voltage code |
| pg_12v_i | input | 1 | 12 V rail power good |
| pg_adj_i | input | 1 | Adjustable rail power good |
| pg_3v3_i | input | 1 | 3.3 V rail power good |
| en_12v_o | output | 1 | 12 V rail enable |
| en_adj_o | output | 1 | Adjustable rail enable |
| en_3v3_o | output | 1 | 3.3 V rail enable |
| pg_c2m_o | output | 1 | Carrier-to-mezzanine power good |
| vcode_o | output | 3 | Latched adjustable-rail voltage code |
| vccpd_sel_o | output | 1 | Pre-driver select, 1 = 3.3 V |
| fault_o | output | 1 | Power-good timeout fault |

## Verification
The bench builds the block with TIMEOUT_CYC = 8 in place of the large default. This lets it count the exact number of cycles a rail stays enabled before the fault is taken, and check that the fault hits on the cycle after the window ends. With this short window, every timeout, abort and reverse-order shutdown path fits in a few dozen cycles. Each switch code and the software-supplied code can then be run through a full power-up and shutdown.

// File: rtl/fmc_pwr_pkg.sv
package fmc_pwr_pkg;
  typedef logic [2:0] vcode_t;

  localparam vcode_t VCODE_SAFE = 3'b110;
  localparam vcode_t VCODE_SW   = 3'b111;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UP12,
    ST_UPADJ,
    ST_UP33,
    ST_ON,
    ST_DN33,
    ST_DNADJ,
    ST_DN12,
    ST_FAULT
  } seq_state_e;

  function automatic logic pre_sel(vcode_t code);
    return code == 3'b000;
  endfunction
endpackage

// File: rtl/fmc_vsel.sv
module fmc_vsel
  import fmc_pwr_pkg::*;
(
  input  vcode_t dip_i,
  input  vcode_t gpio_code_i,
  output vcode_t code_o
);
  // all switches OFF hands the choice to software
  assign code_o = (dip_i == VCODE_SW) ? gpio_code_i : dip_i;
endmodule

// File: rtl/fmc_step_timer.sv
module fmc_step_timer #(
  parameter int unsigned TIMEOUT_CYC = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (run_i && cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/fmc_pwr_seq.sv
module fmc_pwr_seq
  import fmc_pwr_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sw_en_i,
  input  logic       card_prsnt_ni,
  input  logic [2:0] dip_i,
  input  logic [2:0] gpio_code_i,
  input  logic       pg_12v_i,
  input  logic       pg_adj_i,
  input  logic       pg_3v3_i,
  output logic       en_12v_o,
  output logic       en_adj_o,
  output logic       en_3v3_o,
  output logic       pg_c2m_o,
  output logic [2:0] vcode_o,
  output logic       vccpd_sel_o,
  output logic       fault_o
);
  seq_state_e state_q, state_d;
  vcode_t     sel_code, code_q;
  logic       go, waiting, expired;

  assign go      = sw_en_i && !card_prsnt_ni;
  assign waiting = state_q inside {ST_UP12, ST_UPADJ, ST_UP33};

  fmc_vsel u_vsel (
    .dip_i      (dip_i),
    .gpio_code_i(gpio_code_i),
    .code_o     (sel_code)
  );

  fmc_step_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_d != state_q),
    .run_i    (waiting),
    .expired_o(expired)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go) state_d = ST_UP12;
      ST_UP12: begin
        if (!go)           state_d = ST_DN12;
        else if (pg_12v_i) state_d = ST_UPADJ;
        else if (expired)  state_d = ST_FAULT;
      end
      ST_UPADJ: begin
        if (!go)           state_d = ST_DNADJ;
        else if (pg_adj_i) state_d = ST_UP33;
        else if (expired)  state_d = ST_FAULT;
      end
      ST_UP33: begin
        if (!go)           state_d = ST_DN33;
        else if (pg_3v3_i) state_d = ST_ON;
        else if (expired)  state_d = ST_FAULT;
      end
      ST_ON:    if (!go) state_d = ST_DN33;
      ST_DN33:  state_d = ST_DNADJ;
      ST_DNADJ: state_d = ST_DN12;
      ST_DN12:  state_d = ST_IDLE;
      ST_FAULT: if (!go) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= VCODE_SAFE;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && go) code_q <= sel_code;
    end
  end

  assign en_12v_o    = state_q inside {ST_UP12, ST_UPADJ, ST_UP33, ST_ON,
                                       ST_DN33, ST_DNADJ, ST_DN12};
  assign en_adj_o    = state_q inside {ST_UPADJ, ST_UP33, ST_ON, ST_DN33, ST_DNADJ};
  assign en_3v3_o    = state_q inside {ST_UP33, ST_ON, ST_DN33};
  assign pg_c2m_o    = state_q == ST_ON;
  assign fault_o     = state_q == ST_FAULT;
  assign vcode_o     = code_q;
  assign vccpd_sel_o = pre_sel(code_q);
endmodule

// File: rtl/fmc_pwr_seq_chk.sv
module fmc_pwr_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_en_i,
  input logic       card_prsnt_ni,
  input logic       en_12v_o,
  input logic       en_adj_o,
  input logic       en_3v3_o,
  input logic       pg_c2m_o,
  input logic [2:0] vcode_o,
  input logic       vccpd_sel_o,
  input logic       fault_o
);
  a_r1_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_12v_o) |-> ($past(sw_en_i) && !$past(card_prsnt_ni)));

  a_r3_adj_needs_12v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_adj_o |-> en_12v_o);

  a_r4_3v3_needs_adj: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_3v3_o |-> en_adj_o);

  a_r5_pg_needs_rails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_c2m_o |-> (en_12v_o && en_adj_o && en_3v3_o));

  a_r9_fault_rails_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(en_12v_o || en_adj_o || en_3v3_o || pg_c2m_o));

  a_r10_12v_drops_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(en_12v_o) && !fault_o) |-> !$past(en_adj_o));

  a_r11_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_adj_o && $past(en_adj_o)) |-> ($stable(vcode_o) && $stable(vccpd_sel_o)));
endmodule

bind fmc_pwr_seq fmc_pwr_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sw_en_i      (sw_en_i),
  .card_prsnt_ni(card_prsnt_ni),
  .en_12v_o     (en_12v_o),
  .en_adj_o     (en_adj_o),
  .en_3v3_o     (en_3v3_o),
  .pg_c2m_o     (pg_c2m_o),
  .vcode_o      (vcode_o),
  .vccpd_sel_o  (vccpd_sel_o),
  .fault_o      (fault_o)
);

// File: tb/sim_fmc_pwr_seq.sv
module sim_fmc_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_en = 1'b0, card_n = 1'b1;
  logic [2:0] dip = 3'b110, gpio = 3'b000;
  logic pg12 = 1'b0, pgadj = 1'b0, pg33 = 1'b0;
  logic en12, enadj, en33, pgc2m, vsel, fault;
  logic [2:0] vcode;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmc_pwr_seq #(.TIMEOUT_CYC(TMO)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sw_en_i(sw_en), .card_prsnt_ni(card_n),
    .dip_i(dip), .gpio_code_i(gpio), .pg_12v_i(pg12), .pg_adj_i(pgadj),
    .pg_3v3_i(pg33), .en_12v_o(en12), .en_adj_o(enadj), .en_3v3_o(en33),
    .pg_c2m_o(pgc2m), .vcode_o(vcode), .vccpd_sel_o(vsel), .fault_o(fault)
  );

  // {fault, pg_c2m, en_3v3, en_adj, en_12v}
  function automatic logic [4:0] outs();
    return {fault, pgc2m, en33, enadj, en12};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk({3'b0, outs()}, 8'h00, "R12 outputs");
    chk({5'b0, vcode}, 8'd6, "R12 vcode");
    chk({7'b0, vsel}, 8'd0, "R12 vccpd_sel");
  endtask

  task automatic t_gating;
    sw_en = 1'b1; card_n = 1'b1; step(3);
    chk({3'b0, outs()}, 8'h00, "R1 no card");
    sw_en = 1'b0; card_n = 1'b0; step(3);
    chk({3'b0, outs()}, 8'h00, "R1 no enable");
    card_n = 1'b1; step(1);
  endtask

  task automatic t_stepwise;
    dip = 3'b010; pg12 = 0; pgadj = 0; pg33 = 0;
    sw_en = 1'b1; card_n = 1'b0; step(1);
    chk({3'b0, outs()}, 8'b00001, "R2 12V first");
    step(3);
    chk({3'b0, outs()}, 8'b00001, "R2 holds for pg_12v");
    pg12 = 1'b1; step(1);
    chk({3'b0, outs()}, 8'b00011, "R3 adj after pg_12v");
    chk({5'b0, vcode}, 8'd2, "R6 switch code 010");
    step(2);
    chk({3'b0, outs()}, 8'b00011, "R4 holds for pg_adj");
    pgadj = 1'b1; step(1);
    chk({3'b0, outs()}, 8'b00111, "R4 3V3 after pg_adj");
    step(2);
    chk({3'b0, outs()}, 8'b00111, "R5 holds for pg_3v3");
    pg33 = 1'b1; step(1);
    chk({3'b0, outs()}, 8'b01111, "R5 power good last");
    dip = 3'b000; gpio = 3'b000; step(2);
    chk({5'b0, vcode}, 8'd2, "R11 code held");
    chk({7'b0, vsel}, 8'd0, "R11 sel held");
    sw_en = 1'b0; step(1);
    chk({3'b0, outs()}, 8'b00111, "R10 pg_c2m off first");
    step(1);
    chk({3'b0, outs()}, 8'b00011, "R10 3V3 off");
    step(1);
    chk({3'b0, outs()}, 8'b00001, "R10 adj off");
    step(1);
    chk({3'b0, outs()}, 8'b00000, "R10 12V off");
    dip = 3'b110;
  endtask

  task automatic run_code(input logic [2:0] d, input logic [2:0] g, input logic [2:0] exp_code);
    dip = d; gpio = g; pg12 = 1; pgadj = 1; pg33 = 1;
    sw_en = 1'b1; card_n = 1'b0; step(4);
    chk({3'b0, outs()}, 8'b01111, "R5 powered up");
    chk({5'b0, vcode}, {5'b0, exp_code}, (d == 3'b111) ? "R7 software code" : "R6 switch code");
    chk({7'b0, vsel}, {7'b0, exp_code == 3'b000}, "R8 pre-driver select");
    sw_en = 1'b0; step(4);
    chk({3'b0, outs()}, 8'h00, "R10 back to idle");
  endtask

  task automatic t_codes;
    for (int c = 0; c < 7; c++) run_code(c[2:0], 3'b011, c[2:0]);
    run_code(3'b111, 3'b101, 3'b101);
    run_code(3'b111, 3'b000, 3'b000);
  endtask

  task automatic t_timeout;
    pg12 = 1'b1; pgadj = 1'b0; pg33 = 1'b0;
    sw_en = 1'b1; card_n = 1'b0; step(2);
    chk({3'b0, outs()}, 8'b00011, "R9 in adj step");
    step(TMO - 1);
    chk({3'b0, outs()}, 8'b00011, "R9 last wait cycle");
    step(1);
    chk({3'b0, outs()}, 8'b10000, "R9 fault taken");
    step(3);
    chk({3'b0, outs()}, 8'b10000, "R9 fault held");
    sw_en = 1'b0; step(1);
    chk({3'b0, outs()}, 8'b00000, "R9 fault cleared");
  endtask

  task automatic t_abort;
    pg12 = 1'b0; pgadj = 1'b0; pg33 = 1'b0;
    sw_en = 1'b1; card_n = 1'b0; step(1);
    chk({3'b0, outs()}, 8'b00001, "R2 12V on");
    card_n = 1'b1; step(1);
    chk({3'b0, outs()}, 8'b00001, "R10 abort 12V step");
    step(1);
    chk({3'b0, outs()}, 8'b00000, "R10 abort done");
    sw_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    t_reset;
    rst_ni = 1'b1;
    step(1);
    t_reset;
    t_gating;
    t_stepwise;
    t_codes;
    t_timeout;
    t_abort;
    step(2);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule